// File: doc/BRIEF.md
# Sequenced Packet Transmitter

This block turns a single request into a framed byte stream. A request carries a command code, a body length, up to `MAX_BODY` body bytes and a reply tag. When the block is idle it takes the request in one cycle. It gives the frame the next transmit serial number from its own counter and computes the checksum at once. It then sends the frame one byte per valid/ready handshake on its output port.

The serial counter starts at 1 after reset and moves on by one for each accepted frame. When it would reach the reserved value 0 it loads 1 instead. The reply tag marks the frame. A value of zero means the frame was originated by this side. A non-zero value is the serial number of the request this frame answers. At each acceptance a one-cycle strobe reports the serial number given to the frame, so a requester can keep a list of its outstanding transactions.

Top module: `seq_frame_tx`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `req_ready_o` is 1 and both `out_valid_o` and `sn_strobe_o` are 0.
- R2: The first frame after reset carries serial number 1. Each later accepted frame carries the previous serial number plus one.
- R3: After serial number 255 the next frame carries 1. No frame ever carries serial number 0.
- R4: A frame is sent as these bytes in this order: 0x21, checksum, serial number, reply tag, command, length, then the body bytes. Body byte k is `req_body_i[8k+7:8k]`.
- R5: The reply-tag byte equals the value of `req_irsn_i` at acceptance, and 0 marks an originated frame.
- R6: The checksum byte is the sum modulo 256 of every byte that follows it in the frame: serial number, reply tag, command, length and all body bytes.
- R7: An output byte moves on only in a cycle where both `out_valid_o` and `out_ready_i` are 1. While `out_ready_i` is 0, `out_valid_o` stays 1 and `out_data_o` does not change.
- R8: A request is accepted only while `req_ready_o` is 1, and that is the case only when no frame is being sent. A request driven during a frame changes neither the frame's bytes nor the serial numbers.
- R9: In the cycle after acceptance, `sn_strobe_o` is 1 for exactly one cycle and `sn_o` holds the serial number given to that frame.
- R10: A length of zero sends only the six header bytes. After the last byte of any frame, `out_valid_o` falls and `req_ready_o` rises in the next cycle.
- R11: A requested length above `MAX_BODY` is clamped to `MAX_BODY`. The clamped value is both the length byte sent and the number of body bytes sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block is idle and takes a request |
| req_cmd_i | input | 8 | Command code |
| req_len_i | input | 8 | Requested body length |
| req_irsn_i | input | 8 | Reply tag, 0 for an originated frame |
| req_body_i | input | 8*MAX_BODY | Body bytes, byte k at bits 8k+7:8k |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_ready_i | input | 1 | Downstream takes the byte |
| sn_strobe_o | output | 1 | One-cycle pulse after acceptance |
| sn_o | output | 8 | Serial number of the most recently accepted frame |

## Verification
The assertions assume that the downstream side may hold `out_ready_i` low for any number of cycles. They also assume that a request may be held valid at any time, including in the middle of a frame. The stimulus uses three ready patterns: always ready, alternating, and pseudo-random stalls. It also drives junk requests while a frame is being sent. The serial-number step property relies on every accepted frame producing a strobe. The bench therefore sends enough frames to pass the 255-to-1 wrap under that same property.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  localparam int BYTE_W  = 8;
  localparam int HDR_LEN = 6;
  typedef logic [BYTE_W-1:0] byte_t;
  localparam byte_t START_BYTE = 8'h21;
endpackage

// File: rtl/ftx_sn_counter.sv
module ftx_sn_counter
  import ftx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  adv_i,
  output byte_t sn_o
);
  byte_t sn_q;
  byte_t sn_inc;

  assign sn_inc = sn_q + byte_t'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sn_q <= byte_t'(1);
    else if (adv_i) sn_q <= (sn_inc == '0) ? byte_t'(1) : sn_inc; // 0 reserved
  end

  assign sn_o = sn_q;
endmodule

// File: rtl/ftx_csum.sv
module ftx_csum
  import ftx_pkg::*;
#(
  parameter int MAX_BODY = 8
) (
  input  byte_t                       sn_i,
  input  byte_t                       irsn_i,
  input  byte_t                       cmd_i,
  input  byte_t                       len_i,
  input  logic [MAX_BODY*BYTE_W-1:0]  body_i,
  output byte_t                       sum_o
);
  always_comb begin
    sum_o = sn_i + irsn_i + cmd_i + len_i;
    for (int i = 0; i < MAX_BODY; i++) begin
      if (byte_t'(i) < len_i) sum_o = sum_o + body_i[i*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/ftx_byte_sel.sv
module ftx_byte_sel
  import ftx_pkg::*;
#(
  parameter int MAX_BODY = 8
) (
  input  byte_t                       idx_i,
  input  byte_t                       csum_i,
  input  byte_t                       sn_i,
  input  byte_t                       irsn_i,
  input  byte_t                       cmd_i,
  input  byte_t                       len_i,
  input  logic [MAX_BODY*BYTE_W-1:0]  body_i,
  output byte_t                       data_o
);
  always_comb begin
    unique case (idx_i)
      8'd0:    data_o = START_BYTE;
      8'd1:    data_o = csum_i;
      8'd2:    data_o = sn_i;
      8'd3:    data_o = irsn_i;
      8'd4:    data_o = cmd_i;
      8'd5:    data_o = len_i;
      default: begin
        data_o = '0;
        for (int i = 0; i < MAX_BODY; i++) begin
          if (idx_i == byte_t'(HDR_LEN + i)) data_o = body_i[i*BYTE_W +: BYTE_W];
        end
      end
    endcase
  end
endmodule

// File: rtl/seq_frame_tx.sv
module seq_frame_tx
  import ftx_pkg::*;
#(
  parameter int MAX_BODY = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  output logic                       req_ready_o,
  input  logic [7:0]                 req_cmd_i,
  input  logic [7:0]                 req_len_i,
  input  logic [7:0]                 req_irsn_i,
  input  logic [MAX_BODY*8-1:0]      req_body_i,
  output logic                       out_valid_o,
  output logic [7:0]                 out_data_o,
  input  logic                       out_ready_i,
  output logic                       sn_strobe_o,
  output logic [7:0]                 sn_o
);
  localparam int    BODY_W  = MAX_BODY * BYTE_W;
  localparam byte_t MAX_LEN = byte_t'(MAX_BODY);
  localparam byte_t LAST_HDR = byte_t'(HDR_LEN - 1);

  logic              busy_q, strobe_q, accept, fire, last;
  byte_t             idx_q, csum_q, sn_q, irsn_q, cmd_q, len_q;
  logic [BODY_W-1:0] body_q;
  byte_t             sn_cur, len_c, csum_d;

  assign req_ready_o = ~busy_q;
  assign accept      = req_valid_i & ~busy_q;
  assign fire        = busy_q & out_ready_i;
  assign last        = idx_q == (LAST_HDR + len_q);
  assign len_c       = (req_len_i > MAX_LEN) ? MAX_LEN : req_len_i;

  ftx_sn_counter i_sn (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (accept),
    .sn_o  (sn_cur)
  );

  // checksum settled at accept time, so no pass over the body is needed later
  ftx_csum #(.MAX_BODY(MAX_BODY)) i_csum (
    .sn_i  (sn_cur),
    .irsn_i(req_irsn_i),
    .cmd_i (req_cmd_i),
    .len_i (len_c),
    .body_i(req_body_i),
    .sum_o (csum_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      strobe_q <= 1'b0;
      idx_q    <= '0;
      csum_q   <= '0;
      sn_q     <= '0;
      irsn_q   <= '0;
      cmd_q    <= '0;
      len_q    <= '0;
      body_q   <= '0;
    end else begin
      strobe_q <= accept;
      if (accept) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        csum_q <= csum_d;
        sn_q   <= sn_cur;
        irsn_q <= req_irsn_i;
        cmd_q  <= req_cmd_i;
        len_q  <= len_c;
        body_q <= req_body_i;
      end else if (fire) begin
        if (last) busy_q <= 1'b0;
        else      idx_q  <= idx_q + byte_t'(1);
      end
    end
  end

  ftx_byte_sel #(.MAX_BODY(MAX_BODY)) i_sel (
    .idx_i (idx_q),
    .csum_i(csum_q),
    .sn_i  (sn_q),
    .irsn_i(irsn_q),
    .cmd_i (cmd_q),
    .len_i (len_q),
    .body_i(body_q),
    .data_o(out_data_o)
  );

  assign out_valid_o = busy_q;
  assign sn_strobe_o = strobe_q;
  assign sn_o        = sn_q;
endmodule

// File: rtl/ftx_checker.sv
module ftx_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic       out_valid_o,
  input logic [7:0] out_data_o,
  input logic       out_ready_i,
  input logic       sn_strobe_o,
  input logic [7:0] sn_o
);
  logic       seen_q;
  logic [7:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      prev_q <= '0;
    end else if (sn_strobe_o) begin
      seen_q <= 1'b1;
      prev_q <= sn_o;
    end
  end

  a_r7_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  a_r8_idle_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && out_valid_o));

  a_r3_no_zero_sn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sn_strobe_o |-> (sn_o != 8'h00));

  a_r9_strobe_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (sn_strobe_o && out_valid_o));

  a_r4_start_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (out_data_o == 8'h21));

  a_r2_sn_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sn_strobe_o && seen_q) |-> (sn_o == ((prev_q == 8'hFF) ? 8'h01 : prev_q + 8'h01)));
endmodule

bind seq_frame_tx ftx_checker i_ftx_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .out_valid_o(out_valid_o),
  .out_data_o (out_data_o),
  .out_ready_i(out_ready_i),
  .sn_strobe_o(sn_strobe_o),
  .sn_o       (sn_o)
);

// File: tb/test_seq_frame_tx.sv
module test_seq_frame_tx;
  localparam int MAXB = 8;

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic            req_valid_i;
  logic            req_ready_o;
  logic [7:0]      req_cmd_i, req_len_i, req_irsn_i;
  logic [MAXB*8-1:0] req_body_i;
  logic            out_valid_o;
  logic [7:0]      out_data_o;
  logic            out_ready_i;
  logic            sn_strobe_o;
  logic [7:0]      sn_o;

  int   checks = 0;
  int   errors = 0;
  int   frames = 0;
  logic [7:0] exp_sn = 8'd1;
  logic [7:0] lfsr = 8'h5A;
  bit   done = 1'b0;

  always #10 clk_i = ~clk_i;

  seq_frame_tx #(.MAX_BODY(MAXB)) i_seq_frame_tx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_cmd_i(req_cmd_i), .req_len_i(req_len_i), .req_irsn_i(req_irsn_i),
    .req_body_i(req_body_i),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_ready_i(out_ready_i),
    .sn_strobe_o(sn_strobe_o), .sn_o(sn_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic [7:0] cmd, input int len, input logic [7:0] irsn,
                           input int seed, input int mode, input bit poke);
    logic [7:0] ex [0:HDR_MAX-1];
    logic [7:0] body [0:MAXB-1];
    logic [7:0] sum;
    int lc, total, got, cyc;
    lc    = (len > MAXB) ? MAXB : len;
    total = 6 + lc;
    for (int i = 0; i < MAXB; i++) begin
      body[i] = 8'((seed * 7 + i * 13 + 3) % 256);
      req_body_i[i*8 +: 8] = body[i];
    end
    ex[0] = 8'h21; ex[2] = exp_sn; ex[3] = irsn; ex[4] = cmd; ex[5] = 8'(lc);
    for (int i = 0; i < lc; i++) ex[6+i] = body[i];
    sum = 8'h00;
    for (int i = 2; i < total; i++) sum = sum + ex[i];
    ex[1] = sum;

    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R8 ready while idle", req_ready_o, 1);
    req_cmd_i = cmd; req_len_i = 8'(len); req_irsn_i = irsn; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(sn_strobe_o && sn_o == exp_sn, (exp_sn == 8'd1 && frames > 0) ?
        "R3 wrap to 1" : "R9 R2 strobe and serial", {sn_strobe_o, sn_o}, {1'b1, exp_sn});

    got = 0; cyc = 0;
    while (got < total && cyc < 400) begin
      case (mode)
        0: out_ready_i = 1'b1;
        1: out_ready_i = cyc[0];
        default: begin
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          out_ready_i = lfsr[0];
        end
      endcase
      if (poke && got < 2) begin
        req_valid_i = 1'b1; req_cmd_i = 8'hEE; req_irsn_i = 8'h77;
        chk(req_ready_o == 1'b0, "R8 not ready while busy", req_ready_o, 0);
      end else begin
        req_valid_i = 1'b0;
      end
      if (cyc > 0) chk(sn_strobe_o == 1'b0, "R9 strobe single cycle", sn_strobe_o, 0);
      if (!out_valid_o) chk(1'b0, "R7 valid held during frame", 0, 1);
      else if (out_ready_i) begin
        case (got)
          1: chk(out_data_o == ex[got], "R6 checksum", out_data_o, ex[got]);
          2: chk(out_data_o == ex[got], "R2 serial byte", out_data_o, ex[got]);
          3: chk(out_data_o == ex[got], "R5 reply tag", out_data_o, ex[got]);
          5: chk(out_data_o == ex[got], "R11 length byte", out_data_o, ex[got]);
          default: chk(out_data_o == ex[got], "R4 byte order", out_data_o, ex[got]);
        endcase
        got++;
      end
      @(negedge clk_i);
      cyc++;
    end
    req_valid_i = 1'b0;
    out_ready_i = 1'b0;
    chk(!out_valid_o && req_ready_o, "R10 frame ends after last byte",
        {out_valid_o, req_ready_o}, 2'b01);
    exp_sn = (exp_sn == 8'hFF) ? 8'h01 : exp_sn + 8'h01;
    frames++;
  endtask

  localparam int HDR_MAX = 6 + MAXB;

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; req_valid_i = 1'b0; out_ready_i = 1'b0;
    req_cmd_i = '0; req_len_i = '0; req_irsn_i = '0; req_body_i = '0;
    @(negedge clk_i); @(negedge clk_i);
    chk(req_ready_o && !out_valid_o && !sn_strobe_o, "R1 reset state",
        {req_ready_o, out_valid_o, sn_strobe_o}, 3'b100);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o && !out_valid_o && !sn_strobe_o, "R1 after release",
        {req_ready_o, out_valid_o, sn_strobe_o}, 3'b100);

    for (int mode = 0; mode < 3; mode++)
      for (int len = 0; len <= MAXB; len++)
        for (int r = 0; r < 2; r++)
          run_frame(8'(len * 17 + mode), len, (r == 0) ? 8'h00 : 8'(8'h80 + len),
                    len + mode * 11, mode, len == 3);

    run_frame(8'h42, 12, 8'h05, 9, 2, 1'b0);   // R11 clamp
    run_frame(8'h43, 255, 8'h00, 4, 1, 1'b0);  // R11 clamp at max
    while (frames < 270) run_frame(8'(frames), frames % 3, 8'(frames % 5), frames, 0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule